// File: doc/BRIEF.md
# Carry-Save Modular Exponentiator

This block raises a base to an exponent modulo a modulus. Each exponent bit is taken from the most significant end. For every bit the running value is squared. If the bit is one, the running value is then multiplied by the base. Every product is formed by a sequential multiplier that adds one partial product per cycle. Between operations the running value never leaves redundant sum/carry form, so no word-wide carry chain runs before the final step. After each partial product, the bits at or above position W are folded back into W-bit residues using a small table of precomputed constants. This table is supplied with the operands.

When the last exponent bit has been handled, the two words are added once with a ripple adder. The sum is then brought into the range [0, M) by a fixed sequence of trial subtractions of shifted copies of the modulus. A start pulse accepted while idle latches all operands. A one-cycle `done` pulse marks a new `result`, which then holds until the next run finishes.

Top module: `csModExp`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `result` is zero until the first run completes.
- R2: When `foldRes[i*W +: W]` holds 2^(W+i) mod M for i = 0..6 and 1 <= M <= 2^W-1, the result equals base^expo mod M. The base may be any W-bit value, including values at or above M.
- R3: Every result delivered with `done` is strictly less than the modulus latched at the accepted start.
- R4: `done` is a single-cycle pulse. It is high in exactly the cycle that follows the (EXPW + k + 1)*(W + 6)-th rising edge after the edge that accepts `start`, where k is the number of one bits in the exponent.
- R5: A `start` raised while a run is in progress is ignored. Changes to `base`, `expo`, `modulus` or `foldRes` after the accepted start do not alter that run's result or timing.
- R6: `result` keeps its value in every cycle where `done` is low.
- R7: An exponent of zero gives 1 mod M, which is 0 when M = 1. A zero base with a non-zero exponent gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; sampled only when idle |
| base | input | W | Base operand |
| expo | input | EXPW | Exponent, scanned from its top bit |
| modulus | input | W | Modulus M, at least 1 |
| foldRes | input | 7*W | Slot i holds 2^(W+i) mod M |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | W | Reduced residue, held between runs |

## Verification
The checker assumes that the modulus is at least 1 and that the residue table matches the modulus present at the accepted start. It keeps its own copy of that modulus, so operand changes during a run cannot mislead the range check. The bench builds the table from the modulus on every run. It draws moduli only from 1 to 2^W-1, while bases cover the full W-bit range. After the accepted start it deliberately drives garbage operands and extra start pulses, and the checker assumptions still hold through that.

// File: rtl/csx_pkg.sv
package csx_pkg;
  // Guard bits kept above W in each redundant word.
  localparam int GUARD = 4;
  // Bit positions at or above W that the fold maps back through the table.
  localparam int FOLD_POS = GUARD + 3;

  typedef struct packed {
    logic loadInit;
    logic loadSq;
    logic loadMul;
    logic stepMul;
    logic storeProd;
    logic loadFin;
    logic stepRed;
    logic lastRed;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SQLOAD, S_MULLOAD, S_STEP, S_STORE, S_FIN, S_RED, S_DONE
  } phase_t;
endpackage

// File: rtl/csFold.sv
module csFold import csx_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W+GUARD+2:0]    inS,
  input  logic [W+GUARD+2:0]    inC,
  input  logic [FOLD_POS*W-1:0] resTab,
  output logic [W+GUARD-1:0]    outS,
  output logic [W+GUARD-1:0]    outC
);
  localparam int B = W + GUARD;

  // Low W bits of both words plus one table residue per set high bit.
  // The sum of the terms stays below 2^B, so the B-bit pair holds it exactly.
  always_comb begin
    logic [B-1:0] a, b, t, mj;
    a = {{(B-W){1'b0}}, inS[W-1:0]};
    b = {{(B-W){1'b0}}, inC[W-1:0]};
    for (int i = 0; i < FOLD_POS; i++) begin
      t  = inS[W+i] ? {{(B-W){1'b0}}, resTab[i*W +: W]} : '0;
      mj = (a & b) | (a & t) | (b & t);
      a  = a ^ b ^ t;
      b  = mj << 1;
      t  = inC[W+i] ? {{(B-W){1'b0}}, resTab[i*W +: W]} : '0;
      mj = (a & b) | (a & t) | (b & t);
      a  = a ^ b ^ t;
      b  = mj << 1;
    end
    outS = a;
    outC = b;
  end
endmodule

// File: rtl/csxDatapath.sv
module csxDatapath import csx_pkg::*; #(
  parameter int W  = 8,
  parameter int KW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [KW-1:0]         redShift,
  input  logic [W-1:0]          baseIn,
  input  logic [W-1:0]          modIn,
  input  logic [FOLD_POS*W-1:0] tabIn,
  output logic [W-1:0]          result
);
  localparam int B  = W + GUARD;
  localparam int XW = B + 3;
  localparam int FW = B + 1;
  localparam int TW = FW + W;

  logic [W-1:0]          baseR, modR;
  logic [FOLD_POS*W-1:0] tabR;
  logic [B-1:0]          accS, accC, opS, opC, candS, candC, prodS, prodC;
  logic [B-1:0]          nS, nC;
  logic [FW-1:0]         finV, redNext;
  logic [XW-1:0]         dS, dC, ppA, ppB, s1, c1, s2, c2;
  logic [TW-1:0]         trial, finExt;

  // One multiplier position: double the product, add 0, 1 or 2 times the multiplicand.
  always_comb begin
    dS = {2'b00, prodS, 1'b0};
    dC = {2'b00, prodC, 1'b0};
    case ({opS[B-1], opC[B-1]})
      2'b11: begin
        ppA = {2'b00, candS, 1'b0};
        ppB = {2'b00, candC, 1'b0};
      end
      2'b00: begin
        ppA = '0;
        ppB = '0;
      end
      default: begin
        ppA = {3'b000, candS};
        ppB = {3'b000, candC};
      end
    endcase
    s1 = dS ^ dC ^ ppA;
    c1 = ((dS & dC) | (dS & ppA) | (dC & ppA)) << 1;
    s2 = s1 ^ c1 ^ ppB;
    c2 = ((s1 & c1) | (s1 & ppB) | (c1 & ppB)) << 1;
  end

  csFold #(.W(W)) u_fold (
    .inS(s2), .inC(c2), .resTab(tabR), .outS(nS), .outC(nC)
  );

  // Restoring trial subtraction of the modulus shifted left by redShift.
  always_comb begin
    trial   = {{(TW-W){1'b0}}, modR} << redShift;
    finExt  = {{(TW-FW){1'b0}}, finV};
    redNext = (finExt >= trial) ? finV - trial[FW-1:0] : finV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseR <= '0; modR <= '0; tabR <= '0;
      accS <= '0; accC <= '0; opS <= '0; opC <= '0;
      candS <= '0; candC <= '0; prodS <= '0; prodC <= '0;
      finV <= '0; result <= '0;
    end else begin
      if (strb.loadInit) begin
        baseR <= baseIn;
        modR  <= modIn;
        tabR  <= tabIn;
        accS  <= {{(B-1){1'b0}}, 1'b1};
        accC  <= '0;
      end
      if (strb.loadSq || strb.loadMul) begin
        opS   <= accS;
        opC   <= accC;
        prodS <= '0;
        prodC <= '0;
      end
      if (strb.loadSq) begin
        candS <= accS;
        candC <= accC;
      end
      if (strb.loadMul) begin
        candS <= {{(B-W){1'b0}}, baseR};
        candC <= '0;
      end
      if (strb.stepMul) begin
        prodS <= nS;
        prodC <= nC;
        opS   <= opS << 1;
        opC   <= opC << 1;
      end
      if (strb.storeProd) begin
        accS <= prodS;
        accC <= prodC;
      end
      if (strb.loadFin) finV <= {1'b0, accS} + {1'b0, accC};
      if (strb.stepRed) begin
        finV <= redNext;
        if (strb.lastRed) result <= redNext[W-1:0];
      end
    end
  end
endmodule

// File: rtl/csxControl.sv
module csxControl import csx_pkg::*; #(
  parameter int W    = 8,
  parameter int EXPW = 8,
  parameter int KW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [EXPW-1:0] expIn,
  output strobe_t         strb,
  output logic [KW-1:0]   redShift,
  output logic            done
);
  localparam int B   = W + GUARD;
  localparam int CW  = $clog2(B);
  localparam int EIW = (EXPW > 1) ? $clog2(EXPW) : 1;

  phase_t          state;
  logic [EXPW-1:0] expR;
  logic [EIW-1:0]  eIdx;
  logic [CW-1:0]   stepCnt;
  logic            inMul;

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:    strb.loadInit  = start;
      S_SQLOAD:  strb.loadSq    = 1'b1;
      S_MULLOAD: strb.loadMul   = 1'b1;
      S_STEP:    strb.stepMul   = 1'b1;
      S_STORE:   strb.storeProd = 1'b1;
      S_FIN:     strb.loadFin   = 1'b1;
      S_RED: begin
        strb.stepRed = 1'b1;
        strb.lastRed = (redShift == '0);
      end
      default: ;
    endcase
  end

  assign done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      expR     <= '0;
      eIdx     <= '0;
      stepCnt  <= '0;
      inMul    <= 1'b0;
      redShift <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          expR  <= expIn;
          eIdx  <= EIW'(EXPW - 1);
          state <= S_SQLOAD;
        end
        S_SQLOAD: begin
          stepCnt <= '0;
          inMul   <= 1'b0;
          state   <= S_STEP;
        end
        S_MULLOAD: begin
          stepCnt <= '0;
          inMul   <= 1'b1;
          state   <= S_STEP;
        end
        S_STEP:
          if (stepCnt == CW'(B - 1)) state <= S_STORE;
          else stepCnt <= stepCnt + 1'b1;
        S_STORE:
          if (!inMul && expR[eIdx]) state <= S_MULLOAD;
          else if (eIdx == '0) state <= S_FIN;
          else begin
            eIdx  <= eIdx - 1'b1;
            state <= S_SQLOAD;
          end
        S_FIN: begin
          redShift <= KW'(B);
          state    <= S_RED;
        end
        S_RED:
          if (redShift == '0) state <= S_DONE;
          else redShift <= redShift - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csModExp.sv
module csModExp import csx_pkg::*; #(
  parameter int W    = 8,
  parameter int EXPW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [W-1:0]          base,
  input  logic [EXPW-1:0]       expo,
  input  logic [W-1:0]          modulus,
  input  logic [FOLD_POS*W-1:0] foldRes,
  output logic                  done,
  output logic [W-1:0]          result
);
  localparam int KW = $clog2(W + GUARD + 1);

  strobe_t       strb;
  logic [KW-1:0] redShift;

  csxControl #(.W(W), .EXPW(EXPW), .KW(KW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .expIn(expo),
    .strb(strb), .redShift(redShift), .done(done)
  );

  csxDatapath #(.W(W), .KW(KW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .redShift(redShift),
    .baseIn(base), .modIn(modulus), .tabIn(foldRes), .result(result)
  );
endmodule

// File: rtl/csModExpChecker.sv
module csModExpChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] modulus,
  input logic         done,
  input logic [W-1:0] result
);
  logic         idleSeen;
  logic [W-1:0] modSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      idleSeen <= 1'b1;
      modSeen  <= '0;
    end else if (idleSeen && start) begin
      idleSeen <= 1'b0;
      modSeen  <= modulus;
    end else if (done) begin
      idleSeen <= 1'b1;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_done_needs_run: assert property (@(posedge clk) disable iff (rst)
    done |-> !idleSeen);

  a_r3_below_mod: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < modSeen));

  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind csModExp csModExpChecker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .modulus(modulus),
  .done(done), .result(result)
);

// File: tb/sim_csModExp.sv
module sim_csModExp;
  localparam int W    = 8;
  localparam int EXPW = 8;
  localparam int NF   = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [W-1:0]    base = '0;
  logic [EXPW-1:0] expo = '0;
  logic [W-1:0]    modulus = 8'd1;
  logic [NF*W-1:0] foldRes = '0;
  logic            done;
  logic [W-1:0]    result;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  csModExp #(.W(W), .EXPW(EXPW)) u0 (
    .clk(clk), .rst(rst), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .foldRes(foldRes), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint powMod(input longint b, input longint e, input longint m);
    longint r = 1 % m;
    longint x = b % m;
    for (int i = 0; i < EXPW; i++) begin
      if (((e >> i) & 1) == 1) r = (r * x) % m;
      x = (x * x) % m;
    end
    return r;
  endfunction

  function automatic logic [NF*W-1:0] mkTab(input longint m);
    logic [NF*W-1:0] t;
    for (int i = 0; i < NF; i++) t[i*W +: W] = W'((longint'(1) << (W + i)) % m);
    return t;
  endfunction

  // Expected done cycle, result at done, hold afterwards; optional disturbance (R5).
  task automatic runCase(input longint b, input logic [EXPW-1:0] e, input longint m,
                         input bit disturb, input string tag);
    longint expv = powMod(b, longint'(e), m);
    int n = (EXPW + $countones(e) + 1) * (W + 6);
    @(negedge clk);
    base = W'(b); expo = e; modulus = W'(m); foldRes = mkTab(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= n + 3; i++) begin
      if (i > 1) @(negedge clk);
      if (disturb && i >= 3 && i <= 6) begin
        start = (i != 6);
        base = ~base; expo = ~expo; modulus = modulus ^ 8'h5a; foldRes = ~foldRes;
      end
      chk(done === (i == n + 1), "R4 done timing", longint'(done), longint'(i == n + 1));
      if (i == n + 1) begin
        chk(result === W'(expv), tag, longint'(result), expv);
        chk(longint'(result) < m, "R3 result below modulus", longint'(result), m);
      end
      if (i > n + 1) chk(result === W'(expv), "R6 result held", longint'(result), expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done in reset", longint'(done), 0);
    chk(result === '0, "R1 result in reset", longint'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R1 done after reset", longint'(done), 0);
    chk(result === '0, "R1 result after reset", longint'(result), 0);

    runCase(3, 8'd5, 7, 1'b0, "R2 small power");
    runCase(0, 8'd0, 13, 1'b0, "R7 zero exponent");
    runCase(200, 8'd0, 1, 1'b0, "R7 zero exponent unit modulus");
    runCase(0, 8'd37, 11, 1'b0, "R7 zero base");
    runCase(0, 8'd0, 1, 1'b0, "R7 zero base zero exponent");
    runCase(255, 8'hff, 253, 1'b0, "R2 all-ones exponent");
    runCase(254, 8'hff, 254, 1'b0, "R2 even modulus at top");
    runCase(255, 8'hff, 255, 1'b0, "R2 modulus all ones");
    runCase(5, 8'd200, 3, 1'b0, "R2 small modulus");
    runCase(17, 8'd99, 101, 1'b1, "R5 ignored start and operand changes");
    runCase(250, 8'h80, 2, 1'b1, "R5 ignored start with modulus two");
    for (int k = 0; k < 20; k++) begin
      longint m = longint'($urandom % 126) * 2 + 3;
      longint b = longint'($urandom % 256);
      logic [EXPW-1:0] e = EXPW'($urandom);
      runCase(b, e, m, 1'b0, "R2 random operands");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule